// File: doc/BRIEF.md
# Flash High-Voltage Guard Controller

This block sits between the software-visible flash control bits and the charge pump of an on-chip flash array. Software arms a program or an erase, reads back the block-protect register, and then asks for high voltage. The block grants that request only when the arming and read-back order was kept, when the target address lies outside the protected region, and, for a mass erase, only when no block is protected at all.

Once high voltage is on, the block enforces the minimum operation time and the minimum hold time before high voltage may drop. Breaking either one ends the operation early and leaves a sticky sequence-error flag. After high voltage drops, reads of the array stay masked for a recovery window. All of these times are counted in clock cycles set by parameters. The protect register comes out of reset with a non-volatile default. Once it is narrowed below "all open", it can only be rewritten while an external test voltage input is high.

Top module: `flash_hv_guard`

## Requirements
- R1: After reset the control readback is 0, `hv_en`, `busy` and `seq_err` are 0, and `prot_rdata` equals the parameter `PROT_INIT` (default 0xFF).
- R2: The control word has PGM at bit 0, ERASE at bit 1, MASS at bit 2 and HV at bit 3. From idle, a write with exactly one of PGM/ERASE set and HV clear arms that operation; MASS is kept only together with ERASE. Any other write from idle leaves the control readback at 0.
- R3: An HV request (same PGM/ERASE bits with bit 3 set) is ignored unless `prot_re` was pulsed after arming.
- R4: With protect value P other than 0xFF, addresses from 0xC000 + 64·P up to 0xFFFF are locked, and an HV request for a locked `tgt_addr` is ignored. P = 0x00 locks the whole range 0xC000–0xFFFF, and P = 0xFF locks nothing.
- R5: An HV request for a mass erase is ignored whenever the protect value is not 0xFF.
- R6: A protect-register write takes effect when `hv_test` is high or the register currently holds 0xFF; otherwise it is ignored.
- R7: Clearing PGM/ERASE while keeping HV ends the operation normally only after HV has been on for more than `T_OP` cycles. Sooner, or clearing HV while PGM/ERASE is still set, aborts: all control bits clear and `seq_err` sets.
- R8: In the hold phase, clearing HV within `T_NVH` cycles of the PGM/ERASE clear sets `seq_err`. Clearing it later does not. HV drops in both cases.
- R9: `busy` is high while HV is on and for exactly `T_RCV` cycles after HV drops.
- R10: While `busy` is high `arr_dout` reads 0xFF; otherwise it passes `arr_din`.
- R11: `seq_err` stays set until a `stat_clr` pulse.
- R12: Writing PGM and ERASE both 0 while armed returns to idle, and a fresh arm is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write value {HV, MASS, ERASE, PGM} |
| ctl_rdata | output | 4 | Control register readback |
| prot_we | input | 1 | Protect register write strobe |
| prot_wdata | input | 8 | Protect register write value |
| prot_re | input | 1 | Protect register read strobe |
| prot_rdata | output | 8 | Protect register value |
| hv_test | input | 1 | External test voltage present |
| tgt_addr | input | 16 | Address of the program/erase target |
| stat_clr | input | 1 | Clears the sequence-error flag |
| seq_err | output | 1 | Sticky sequence-error flag |
| busy | output | 1 | Operation or recovery in progress |
| hv_en | output | 1 | High-voltage enable to the charge pump |
| arr_din | input | 8 | Data read from the flash array |
| arr_dout | output | 8 | Data returned to readers |

## Verification
The bench sweeps protect values across the region boundary: just below and at the computed start address, with 0x00 and 0xFF as the extremes. An off-by-one start address or a missing 0xFF exception would grant or refuse HV on the wrong side. It asks for HV with the protect read skipped and with a mass erase under partial protection. A guard that ignored either condition would raise `hv_en`. Early PGM clears and early HV clears show whether the timers catch short windows or let them pass silently. The recovery window is sampled on its last busy cycle and on the first free cycle, so a design that counted one cycle too many or too few would fail.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_READY,
        ST_HV,
        ST_HOLD,
        ST_RCV
    } seq_state_e;

    // bit 3 .. bit 0
    typedef struct packed {
        logic hv;
        logic mass;
        logic erase;
        logic pgm;
    } ctl_bits_t;

endpackage

// File: rtl/fg_prot_guard.sv
module fg_prot_guard #(
    parameter int          ADDR_W    = 16,
    parameter int          PROT_W    = 8,
    parameter logic [7:0]  PROT_INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_we,
    input  logic [PROT_W-1:0] prot_wdata,
    input  logic              hv_test,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [PROT_W-1:0] prot_q,
    output logic              addr_locked,
    output logic              all_open
);
    localparam int BLK_SH = ADDR_W - PROT_W - 2;

    logic [PROT_W-1:0] prot_d;
    logic [ADDR_W-1:0] lock_start;

    always_comb begin
        prot_d = prot_q;
        if (prot_we && (hv_test || (prot_q == {PROT_W{1'b1}})))
            prot_d = prot_wdata;
        all_open    = (prot_q == {PROT_W{1'b1}});
        lock_start  = {2'b11, prot_q, {BLK_SH{1'b0}}};
        addr_locked = !all_open && (tgt_addr >= lock_start);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= PROT_W'(PROT_INIT);
        else        prot_q <= prot_d;
    end

    // R6: writes without test voltage cannot alter a narrowed register
    a_r6_prot_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_we && !hv_test && prot_q != {PROT_W{1'b1}}) |=> $stable(prot_q));

endmodule

// File: rtl/fg_sequencer.sv
module fg_sequencer
    import flash_guard_pkg::*;
#(
    parameter int T_OP  = 240,
    parameter int T_NVH = 40,
    parameter int T_RCV = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_we,
    input  ctl_bits_t ctl_wdata,
    input  logic      prot_re,
    input  logic      addr_locked,
    input  logic      all_open,
    input  logic      stat_clr,
    output ctl_bits_t ctl_q,
    output logic      seq_err,
    output logic      busy
);
    localparam int MAX_T = (T_OP > T_NVH) ? ((T_OP > T_RCV) ? T_OP : T_RCV)
                                          : ((T_NVH > T_RCV) ? T_NVH : T_RCV);
    localparam int TMR_W = $clog2(MAX_T + 2) + 1;
    localparam logic [TMR_W-1:0] OP_LIM  = TMR_W'(T_OP);
    localparam logic [TMR_W-1:0] NVH_LIM = TMR_W'(T_NVH);
    localparam logic [TMR_W-1:0] RCV_END = TMR_W'(T_RCV - 1);

    typedef struct packed {
        seq_state_e       st;
        ctl_bits_t        ctl;
        logic [TMR_W-1:0] tmr;
        logic             err;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      same_op, grant_ok;

    always_comb begin
        r_d      = r_q;
        r_d.tmr  = (r_q.tmr == {TMR_W{1'b1}}) ? r_q.tmr : r_q.tmr + 1'b1;
        same_op  = (ctl_wdata.pgm == r_q.ctl.pgm) && (ctl_wdata.erase == r_q.ctl.erase);
        grant_ok = !addr_locked && !(r_q.ctl.mass && !all_open);
        if (stat_clr) r_d.err = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (ctl_we && (ctl_wdata.pgm ^ ctl_wdata.erase) && !ctl_wdata.hv) begin
                    r_d.ctl.pgm   = ctl_wdata.pgm;
                    r_d.ctl.erase = ctl_wdata.erase;
                    r_d.ctl.mass  = ctl_wdata.erase && ctl_wdata.mass;
                    r_d.st        = ST_ARMED;
                end
            end
            ST_ARMED, ST_READY: begin
                if (prot_re && r_q.st == ST_ARMED) r_d.st = ST_READY;
                if (ctl_we) begin
                    if (!ctl_wdata.pgm && !ctl_wdata.erase) begin
                        r_d.ctl = '0;
                        r_d.st  = ST_IDLE;
                    end else if (ctl_wdata.hv && same_op && r_q.st == ST_READY && grant_ok) begin
                        r_d.ctl.hv = 1'b1;
                        r_d.st     = ST_HV;
                        r_d.tmr    = '0;
                    end
                end
            end
            ST_HV: begin
                if (ctl_we) begin
                    if (ctl_wdata.hv && !ctl_wdata.pgm && !ctl_wdata.erase && r_q.tmr >= OP_LIM) begin
                        r_d.ctl = '{hv: 1'b1, default: 1'b0};
                        r_d.st  = ST_HOLD;
                        r_d.tmr = '0;
                    end else if (!ctl_wdata.hv || (!ctl_wdata.pgm && !ctl_wdata.erase)) begin
                        r_d.ctl = '0;
                        r_d.err = 1'b1;
                        r_d.st  = ST_RCV;
                        r_d.tmr = '0;
                    end
                end
            end
            ST_HOLD: begin
                if (ctl_we && !ctl_wdata.hv) begin
                    r_d.ctl = '0;
                    r_d.st  = ST_RCV;
                    r_d.tmr = '0;
                    if (r_q.tmr < NVH_LIM) r_d.err = 1'b1;
                end
            end
            ST_RCV: begin
                if (r_q.tmr >= RCV_END) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, ctl: '0, tmr: '0, err: 1'b0};
        else        r_q <= r_d;
    end

    assign ctl_q   = r_q.ctl;
    assign seq_err = r_q.err;
    assign busy    = (r_q.st == ST_HV) || (r_q.st == ST_HOLD) || (r_q.st == ST_RCV);

    // R3: high voltage only rises out of the read-back state
    a_r3_hv_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.hv) |-> $past(r_q.st == ST_READY));
    // R4: high voltage never rises for a locked target
    a_r4_no_hv_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.hv) |-> $past(!addr_locked));
    // R9: recovery keeps busy set once high voltage drops
    a_r9_busy_after_hv: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.hv) |-> busy);
    // R11: error flag persists without a clear
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !stat_clr) |=> seq_err);

endmodule

// File: rtl/flash_hv_guard.sv
module flash_hv_guard
    import flash_guard_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         PROT_W    = 8,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] PROT_INIT = 8'hFF,
    parameter int         T_OP      = 240,
    parameter int         T_NVH     = 40,
    parameter int         T_RCV     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [3:0]        ctl_wdata,
    output logic [3:0]        ctl_rdata,
    input  logic              prot_we,
    input  logic [PROT_W-1:0] prot_wdata,
    input  logic              prot_re,
    output logic [PROT_W-1:0] prot_rdata,
    input  logic              hv_test,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              stat_clr,
    output logic              seq_err,
    output logic              busy,
    output logic              hv_en,
    input  logic [DATA_W-1:0] arr_din,
    output logic [DATA_W-1:0] arr_dout
);
    ctl_bits_t ctl_w, ctl_q;
    logic      addr_locked, all_open;

    assign ctl_w = ctl_bits_t'(ctl_wdata);

    fg_prot_guard #(
        .ADDR_W(ADDR_W), .PROT_W(PROT_W), .PROT_INIT(PROT_INIT)
    ) u_prot (
        .clk(clk), .rst_n(rst_n), .prot_we(prot_we), .prot_wdata(prot_wdata),
        .hv_test(hv_test), .tgt_addr(tgt_addr), .prot_q(prot_rdata),
        .addr_locked(addr_locked), .all_open(all_open)
    );

    fg_sequencer #(
        .T_OP(T_OP), .T_NVH(T_NVH), .T_RCV(T_RCV)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_w),
        .prot_re(prot_re), .addr_locked(addr_locked), .all_open(all_open),
        .stat_clr(stat_clr), .ctl_q(ctl_q), .seq_err(seq_err), .busy(busy)
    );

    assign ctl_rdata = ctl_q;
    assign hv_en     = ctl_q.hv;
    assign arr_dout  = busy ? {DATA_W{1'b1}} : arr_din;

endmodule

// File: tb/flash_hv_guard_test.sv
module flash_hv_guard_test;
    localparam int T_OP = 20, T_NVH = 4, T_RCV = 6;

    logic clk = 0, rst_n = 0;
    logic ctl_we = 0, prot_we = 0, prot_re = 0, hv_test = 0, stat_clr = 0;
    logic [3:0] ctl_wdata = 0, ctl_rdata;
    logic [7:0] prot_wdata = 0, prot_rdata, arr_din = 8'h5A, arr_dout;
    logic [15:0] tgt_addr = 0;
    logic seq_err, busy, hv_en;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    flash_hv_guard #(.T_OP(T_OP), .T_NVH(T_NVH), .T_RCV(T_RCV)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .prot_we(prot_we), .prot_wdata(prot_wdata),
        .prot_re(prot_re), .prot_rdata(prot_rdata), .hv_test(hv_test),
        .tgt_addr(tgt_addr), .stat_clr(stat_clr), .seq_err(seq_err),
        .busy(busy), .hv_en(hv_en), .arr_din(arr_din), .arr_dout(arr_dout)
    );

    // {prot[31:24], addr[23:8], grant[0]}
    localparam logic [31:0] VEC [9] = '{
        {8'hFF, 16'hFFFF, 8'd1},
        {8'h00, 16'hC000, 8'd0},
        {8'h00, 16'hFFFF, 8'd0},
        {8'h80, 16'hE000, 8'd0},
        {8'h80, 16'hDFFF, 8'd1},
        {8'hFE, 16'hFF80, 8'd0},
        {8'hFE, 16'hFF7F, 8'd1},
        {8'h01, 16'hC03F, 8'd1},
        {8'h01, 16'hC040, 8'd0}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_wr(logic [3:0] v);
        ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
    endtask

    task automatic prot_wr(logic [7:0] v, logic t);
        prot_we = 1; prot_wdata = v; hv_test = t; @(negedge clk);
        prot_we = 0; hv_test = 0;
    endtask

    task automatic prot_rd();
        prot_re = 1; @(negedge clk); prot_re = 0;
    endtask

    task automatic finish_ok();
        cyc(T_OP + 2); ctl_wr(4'b1000); cyc(T_NVH + 2); ctl_wr(4'b0000); cyc(T_RCV + 2);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 prot", prot_rdata, 8'hFF);
        chk("R1 busy/err/hv", {busy, seq_err, hv_en}, 0);

        // R4 protected range table
        for (int i = 0; i < 9; i++) begin
            prot_wr(VEC[i][31:24], 1'b1);
            tgt_addr = VEC[i][23:8];
            ctl_wr(4'b0010); prot_rd(); ctl_wr(4'b1010);
            chk($sformatf("R4 vec%0d hv", i), hv_en, VEC[i][0]);
            if (hv_en) finish_ok();
            else ctl_wr(4'b0000);
        end

        prot_wr(8'hFF, 1'b1); tgt_addr = 16'hD000;
        // R2 both op bits refused, single accepted
        ctl_wr(4'b0011); chk("R2 both refused", ctl_rdata, 0);
        ctl_wr(4'b0101); chk("R2 pgm arm drops mass", ctl_rdata, 4'b0001);
        // R12 disarm then rearm
        ctl_wr(4'b0000); chk("R12 disarm", ctl_rdata, 0);
        ctl_wr(4'b0001); chk("R12 rearm", ctl_rdata, 4'b0001);
        // R3 skipped read
        ctl_wr(4'b1001); chk("R3 no read no hv", hv_en, 0);
        prot_rd(); ctl_wr(4'b1001); chk("R3 after read hv", hv_en, 1);
        // R10 read mask while busy
        chk("R10 busy masks", arr_dout, 8'hFF);
        // R9 recovery length
        cyc(T_OP + 2); ctl_wr(4'b1000); cyc(T_NVH + 2); ctl_wr(4'b0000);
        chk("R8 clean no err", seq_err, 0);
        chk("R9 busy start", busy, 1);
        cyc(T_RCV - 1); chk("R9 busy last", busy, 1);
        cyc(1); chk("R9 free", busy, 0);
        chk("R10 passthrough", arr_dout, 8'h5A);

        // R7 early clear aborts
        ctl_wr(4'b0001); prot_rd(); ctl_wr(4'b1001); cyc(2); ctl_wr(4'b1000);
        chk("R7 abort hv", hv_en, 0);
        chk("R7 abort err", seq_err, 1);
        cyc(T_RCV + 2);
        chk("R11 sticky", seq_err, 1);
        stat_clr = 1; cyc(1); stat_clr = 0;
        chk("R11 cleared", seq_err, 0);

        // R7 HV dropped with op still set
        ctl_wr(4'b0010); prot_rd(); ctl_wr(4'b1010); cyc(T_OP + 2); ctl_wr(4'b0010);
        chk("R7 hv-first err", {hv_en, seq_err}, 2'b01);
        cyc(T_RCV + 2); stat_clr = 1; cyc(1); stat_clr = 0;

        // R8 hold too short
        ctl_wr(4'b0001); prot_rd(); ctl_wr(4'b1001); cyc(T_OP + 2); ctl_wr(4'b1000);
        chk("R8 hold hv", ctl_rdata, 4'b1000);
        ctl_wr(4'b0000);
        chk("R8 short hold err", {hv_en, seq_err}, 2'b01);
        cyc(T_RCV + 2); stat_clr = 1; cyc(1); stat_clr = 0;

        // R5 mass erase
        ctl_wr(4'b0110); prot_rd(); ctl_wr(4'b1110);
        chk("R5 mass open", ctl_rdata, 4'b1110);
        finish_ok();
        prot_wr(8'h80, 1'b1); tgt_addr = 16'hC000;
        ctl_wr(4'b0110); prot_rd(); ctl_wr(4'b1110);
        chk("R5 mass refused", hv_en, 0);
        ctl_wr(4'b0000);
        ctl_wr(4'b0010); prot_rd(); ctl_wr(4'b1010);
        chk("R5 plain erase ok", hv_en, 1);
        finish_ok();

        // R6 protect write gating
        prot_wr(8'h40, 1'b0); chk("R6 ignored", prot_rdata, 8'h80);
        prot_wr(8'h40, 1'b1); chk("R6 test write", prot_rdata, 8'h40);
        prot_wr(8'hFF, 1'b1); prot_wr(8'h10, 1'b0);
        chk("R6 open write", prot_rdata, 8'h10);

        summary();
    end
endmodule